// File: doc/BRIEF.md
# Sequential Shift-Add Unsigned Multiplier

This block multiplies two unsigned `WIDTH`-bit operands over several clock cycles with a single adder. It keeps three registers. One holds the multiplicand. One is the accumulator for the high half of the product. The third starts out holding the multiplier and, as the bits of the multiplier are used, fills up with the low half of the product.

On each working cycle the bit of the low register at the bottom decides whether the multiplicand is added into the accumulator. The carry of that sum, the accumulator and the low register then move down one place as a single chain. After `WIDTH` such steps the high half of the product is on `hiOut` and the low half on `loOut`. A one-cycle `done` pulse marks the result.

A caller raises `startReq` with both operands while `busy` is low. It then waits for `done`. The result stays on the outputs until the next accepted start.

Top module: `mulShiftAdd`

## Requirements
- R1: After reset `busy`, `done`, `hiOut` and `loOut` are all 0.
- R2: A `startReq` sampled while `busy` is 0 is accepted. From the next cycle `busy` is 1, `hiOut` reads 0 and `loOut` reads the multiplier operand.
- R3: An accepted operation takes exactly `WIDTH` working cycles. `done` is 1 for exactly one cycle, in the first cycle after the last step, and `busy` falls to 0 on the same edge.
- R4: While `done` is 1, `{hiOut, loOut}` equals the unsigned product of the two operands. `hiOut` holds bits [2*WIDTH-1:WIDTH] and `loOut` holds bits [WIDTH-1:0].
- R5: A `startReq` sampled while `busy` is 1 is ignored. It neither restarts nor lengthens the operation, and it does not change the final product.
- R6: While `busy` is 0 and no start is accepted, `hiOut` and `loOut` keep their values from one clock edge to the next.
- R7: The carry out of each addition enters the top bit of the high register. All-ones operands therefore give the full product (2^WIDTH-1)^2 without losing a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request to begin a multiply with the operands presented this cycle |
| multiplicand | input | WIDTH | Unsigned multiplicand operand |
| multiplier | input | WIDTH | Unsigned multiplier operand |
| busy | output | 1 | High while steps are in progress |
| done | output | 1 | One-cycle pulse when the product is ready |
| hiOut | output | WIDTH | Upper half of the product register chain |
| loOut | output | WIDTH | Lower half of the product register chain |

## Verification
The bench uses zero and one as operands to separate a dropped add from a wrong shift. It uses all-ones operands to show whether the carry reaches the top of the high register. Single-bit powers of two check that the shift count is exactly `WIDTH`, since one step too many or too few moves the lone product bit. Random operands cover the general case. In some runs the bench raises a start in the middle of the operation, and a reload or a restart then shows up as a wrong product or a wrong cycle count.

// File: rtl/mulPkg.sv
package mulPkg;

  // Strobes issued by the sequencer to the register datapath.
  typedef struct packed {
    logic load;   // capture operands, clear accumulator
    logic step;   // one conditional add and one right shift
  } mulStrobeT;

  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mulStateT;

endpackage

// File: rtl/mulControl.sv
module mulControl
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  output mulStrobeT strobes,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  mulStateT         state;
  logic [CNT_W-1:0] stepCnt;
  logic             lastStep;

  assign lastStep = (stepCnt == LAST_STEP);

  always_comb begin
    strobes.load = (state == ST_IDLE) && startReq;
    strobes.step = (state == ST_RUN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      done <= strobes.step && lastStep;
      if (strobes.load) begin
        state   <= ST_RUN;
        stepCnt <= '0;
      end else if (strobes.step) begin
        if (lastStep) begin
          state   <= ST_IDLE;
          stepCnt <= '0;
        end else begin
          stepCnt <= stepCnt + 1'b1;
        end
      end
    end
  end

  assign busy = (state == ST_RUN);

endmodule

// File: rtl/mulDatapath.sv
module mulDatapath
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  mulStrobeT        strobes,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  localparam int SUM_W = WIDTH + 1;

  logic [WIDTH-1:0] mdReg;
  logic [WIDTH-1:0] hiReg;
  logic [WIDTH-1:0] loReg;
  logic [WIDTH-1:0] addend;
  logic [SUM_W-1:0] partialSum;

  // Bottom multiplier bit gates the multiplicand into the adder.
  assign addend     = loReg[0] ? mdReg : '0;
  assign partialSum = {1'b0, hiReg} + {1'b0, addend};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mdReg <= '0;
      hiReg <= '0;
      loReg <= '0;
    end else if (strobes.load) begin
      mdReg <= multiplicand;
      hiReg <= '0;
      loReg <= multiplier;
    end else if (strobes.step) begin
      // {carry, sum, lo} moves down one place as one chain.
      hiReg <= partialSum[SUM_W-1:1];
      loReg <= {partialSum[0], loReg[WIDTH-1:1]};
    end
  end

  assign hiOut = hiReg;
  assign loOut = loReg;

endmodule

// File: rtl/mulShiftAdd.sv
module mulShiftAdd
  import mulPkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic [WIDTH-1:0] multiplicand,
  input  logic [WIDTH-1:0] multiplier,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] hiOut,
  output logic [WIDTH-1:0] loOut
);

  mulStrobeT strobes;

  mulControl #(.WIDTH(WIDTH)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .strobes  (strobes),
    .busy     (busy),
    .done     (done)
  );

  mulDatapath #(.WIDTH(WIDTH)) uPath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .multiplicand (multiplicand),
    .multiplier   (multiplier),
    .hiOut        (hiOut),
    .loOut        (loOut)
  );

endmodule

// File: rtl/mulShiftAddChecker.sv
module mulShiftAddChecker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             startReq,
  input logic [WIDTH-1:0] multiplier,
  input logic             busy,
  input logic             done,
  input logic [WIDTH-1:0] hiOut,
  input logic [WIDTH-1:0] loOut
);

  localparam int CNT_W = $clog2(WIDTH + 2);

  // Counts working cycles since the last accepted start.
  logic [CNT_W-1:0] runCnt;
  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= '0;
    else if (startReq && !busy) runCnt <= '0;
    else if (busy) runCnt <= runCnt + 1'b1;
  end

  // R2: accepted start makes busy high and clears the accumulator
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rstN)
    (startReq && !busy) |=> (busy && hiOut == '0 && loOut == $past(multiplier)));

  // R3: done lasts exactly one cycle
  a_r3_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R3: busy falls only together with done
  a_r3_busy_fall_done: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R3: done appears after exactly WIDTH working cycles
  a_r3_step_count: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (runCnt == CNT_W'(WIDTH)));

  // R5: a start during a run never drops busy early
  a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && startReq && runCnt < CNT_W'(WIDTH - 1)) |=> busy);

  // R6: idle without start holds the outputs
  a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !startReq) |=> ($stable(hiOut) && $stable(loOut)));

endmodule

bind mulShiftAdd mulShiftAddChecker #(.WIDTH(WIDTH)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .startReq   (startReq),
  .multiplier (multiplier),
  .busy       (busy),
  .done       (done),
  .hiOut      (hiOut),
  .loOut      (loOut)
);

// File: tb/sim_mulShiftAdd.sv
module sim_mulShiftAdd;

  localparam int W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int WATCHDOG_CYCLES = 100000;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         startReq = 1'b0;
  logic [W-1:0] multiplicand = '0;
  logic [W-1:0] multiplier = '0;
  logic         busy, done;
  logic [W-1:0] hiOut, loOut;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mulShiftAdd #(.WIDTH(W)) u0 (
    .clk(clk), .rstN(rstN), .startReq(startReq),
    .multiplicand(multiplicand), .multiplier(multiplier),
    .busy(busy), .done(done), .hiOut(hiOut), .loOut(loOut)
  );

  function automatic logic [2*W-1:0] expProd(logic [W-1:0] a, logic [W-1:0] b);
    logic [2*W-1:0] wa, wb;
    wa = {{W{1'b0}}, a};
    wb = {{W{1'b0}}, b};
    return wa * wb;
  endfunction

  task automatic check(bit ok, string req, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // One multiply; optionally pokes startReq mid-run with other operands.
  task automatic runMul(logic [W-1:0] a, logic [W-1:0] b, bit poke, string tag);
    int n;
    logic [2*W-1:0] hold;
    @(negedge clk);
    multiplicand = a; multiplier = b; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    check(busy == 1'b1 && hiOut == '0 && loOut == b, "R2 load",
          {hiOut, loOut}, {{W{1'b0}}, b});
    n = 0;
    while (n < 4 * W) begin
      if (poke && n == 3) begin
        multiplicand = ~a; multiplier = ~b; startReq = 1'b1;
      end
      @(negedge clk);
      startReq = 1'b0;
      n++;
      if (done) break;
    end
    check(n == W && busy == 1'b0, poke ? "R5 cycles after busy start" : "R3 cycles",
          (2*W)'(n), (2*W)'(W));
    check({hiOut, loOut} == expProd(a, b), poke ? "R5 product" : tag,
          {hiOut, loOut}, expProd(a, b));
    hold = {hiOut, loOut};
    @(negedge clk);
    check(done == 1'b0, "R3 done single pulse", (2*W)'(done), '0);
    check({hiOut, loOut} == hold, "R6 hold", {hiOut, loOut}, hold);
  endtask

  initial begin : watchdog
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin : stim
    logic [W-1:0] ra, rb;
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && hiOut == 0 && loOut == 0, "R1 reset",
          {hiOut, loOut}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && hiOut == 0 && loOut == 0, "R1 after release",
          {hiOut, loOut}, '0);

    runMul('0, '0, 1'b0, "R4 zero*zero");
    runMul(16'h1234, '0, 1'b0, "R4 x*zero");
    runMul('0, 16'hBEEF, 1'b0, "R4 zero*x");
    runMul(16'd1, 16'hA5C3, 1'b0, "R4 one*x");
    runMul(16'h3C5A, 16'd1, 1'b0, "R4 x*one");
    runMul('1, '1, 1'b0, "R7 allones");
    runMul('1, 16'd1, 1'b0, "R7 allones*one");
    runMul(16'h8000, 16'h8000, 1'b0, "R4 top bits");
    runMul(16'h0001, 16'h8000, 1'b0, "R4 single bit");
    runMul(16'h00FF, 16'hFF00, 1'b0, "R4 split");
    runMul(16'h4321, 16'h0F0F, 1'b1, "R5 busy start");

    // R6: idle clocks with no start keep the last product
    begin
      logic [2*W-1:0] hold;
      hold = {hiOut, loOut};
      repeat (5) @(negedge clk);
      check({hiOut, loOut} == hold, "R6 idle hold", {hiOut, loOut}, hold);
    end

    for (int i = 0; i < 40; i++) begin
      ra = W'($urandom);
      rb = W'($urandom);
      runMul(ra, rb, (i % 8) == 5, "R4 random");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule